// File: doc/BRIEF.md
# Counting Bloom Filter Lockset Register

This block keeps a compact summary of the locks one hardware thread holds at a moment. Each lock address is hashed into four partitions of four bits, and one bit is marked in each partition, so the whole set fits in a 16-bit signature. A per-line race checker reads this signature and intersects it with the candidate set it keeps for each cache line.

Removing a lock from a plain Bloom filter would wipe out bits that other held locks share. To avoid this, every filter bit has a 2-bit counter behind it. Acquiring a lock increments the four counters it selects. Releasing the lock decrements them. A filter bit reads as set while its counter is nonzero. Acquire and release each have their own command port. Each command takes effect at the clock edge where it is sampled.

Top module: `lockset_bloom_reg`

## Requirements
- R1: `lockset` bit i is 1 exactly when counter i is nonzero. Partition p occupies bits [4p+3:4p].
- R2: For a lock address `a`, the index in partition p is `a[2p+1:2p] ^ a[2p+9:2p+8]`. The selected bit is 4p plus that index, so one lock selects exactly one bit per partition.
- R3: An acquire increments each of its four selected counters. A counter already at 3 stays at 3.
- R4: A release decrements each of its four selected counters. A filter bit clears when its counter reaches 0, and bits still held by another lock through a shared counter stay set.
- R5: An acquire that finds a counter already at 3 marks that counter as overflowed. From then until reset, a release never takes that counter below 1, so its filter bit stays set.
- R6: A release that selects a counter already at 0 leaves that counter unchanged. It drives `rel_err` high for the one cycle after the command edge. `rel_err` is 0 whenever no release was sampled at the previous edge.
- R7: When acquire and release are sampled at the same edge, the release is applied first and the acquire second. A counter at 0 that both commands select therefore flags `rel_err` and ends at 1.
- R8: A synchronous active-high `rst` clears all counters, all overflow marks and `rel_err`, so `lockset` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_valid | input | 1 | Acquire command strobe |
| acq_addr | input | 16 | Address of the lock being acquired |
| rel_valid | input | 1 | Release command strobe |
| rel_addr | input | 16 | Address of the lock being released |
| lockset | output | 16 | Bloom filter signature of the held locks |
| rel_err | output | 1 | Release hit a zero counter at the previous edge |

## Verification
The cell assertions check every cycle:
- a counter's single-step increment and decrement;
- the zero floor on release;
- the floor of 1 on an overflowed counter.

The top-level assertions check every cycle:
- that an error pulse always follows a release;
- that reset empties the signature.

Only the bench's scenarios can show the following, because each depends on a sequence of addresses and their expected signatures:
- the hash mapping;
- shared bits surviving a release when two locks collide;
- the release-before-acquire order;
- the recovery of a full count after reset.

// File: rtl/lockset_pkg.sv
package lockset_pkg;
    localparam int ADDR_W   = 16;
    localparam int NPART    = 4;
    localparam int PBITS    = 4;
    localparam int IDX_W    = $clog2(PBITS);
    localparam int NBITS    = NPART * PBITS;
    localparam int CNT_W    = 2;
    localparam int HASH_GAP = 8;

    typedef logic [CNT_W-1:0] cnt_t;
    localparam cnt_t CNT_MAX = {CNT_W{1'b1}};

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_INC  = 2'b01,
        OP_DEC  = 2'b10,
        OP_BOTH = 2'b11
    } cell_op_e;

    // Index inside partition p: XOR of two fixed address fields.
    function automatic logic [IDX_W-1:0] part_index(
        input logic [ADDR_W-1:0] addr,
        input int p
    );
        return addr[IDX_W*p +: IDX_W] ^ addr[IDX_W*p + HASH_GAP +: IDX_W];
    endfunction
endpackage

// File: rtl/lockset_hash.sv
module lockset_hash
    import lockset_pkg::*;
(
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic [NBITS-1:0]  mask
);
    for (genvar p = 0; p < NPART; p++) begin : g_part
        logic [IDX_W-1:0] idx;
        assign idx = part_index(addr, p);
        for (genvar b = 0; b < PBITS; b++) begin : g_bit
            assign mask[p*PBITS + b] = en && (idx == IDX_W'(b));
        end
    end
endmodule

// File: rtl/lockset_cell.sv
module lockset_cell
    import lockset_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output cnt_t cnt,
    output logic zero_hit
);
    logic     lost;
    cnt_t     mid;
    cnt_t     nxt;
    logic     lost_nxt;
    cell_op_e op;

    assign op       = cell_op_e'({dec, inc});
    assign zero_hit = dec && (cnt == '0);

    always_comb begin
        // Release is applied first.
        mid = cnt;
        if (op == OP_DEC || op == OP_BOTH) begin
            if (cnt == '0)
                mid = cnt;
            else if (lost && cnt == cnt_t'(1))
                mid = cnt;
            else
                mid = cnt - cnt_t'(1);
        end
        nxt      = mid;
        lost_nxt = lost;
        if (op == OP_INC || op == OP_BOTH) begin
            if (mid == CNT_MAX)
                lost_nxt = 1'b1;
            else
                nxt = mid + cnt_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            lost <= 1'b0;
        end else begin
            cnt  <= nxt;
            lost <= lost_nxt;
        end
    end

    a_r3_inc_step: assert property (@(posedge clk) disable iff (rst)
        (inc && !dec && cnt != CNT_MAX) |=> cnt == $past(cnt) + cnt_t'(1));
    a_r4_dec_step: assert property (@(posedge clk) disable iff (rst)
        (dec && !inc && cnt > cnt_t'(1)) |=> cnt == $past(cnt) - cnt_t'(1));
    a_r6_zero_hold: assert property (@(posedge clk) disable iff (rst)
        (dec && !inc && cnt == '0) |=> cnt == '0);
    a_r5_lost_floor: assert property (@(posedge clk) disable iff (rst)
        lost |-> cnt != '0);
endmodule

// File: rtl/lockset_bloom_reg.sv
module lockset_bloom_reg
    import lockset_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acq_valid,
    input  logic [ADDR_W-1:0] acq_addr,
    input  logic              rel_valid,
    input  logic [ADDR_W-1:0] rel_addr,
    output logic [NBITS-1:0]  lockset,
    output logic              rel_err
);
    logic [NBITS-1:0] acq_mask;
    logic [NBITS-1:0] rel_mask;
    logic [NBITS-1:0] zero_hits;

    lockset_hash u_acq_hash (.en(acq_valid), .addr(acq_addr), .mask(acq_mask));
    lockset_hash u_rel_hash (.en(rel_valid), .addr(rel_addr), .mask(rel_mask));

    for (genvar i = 0; i < NBITS; i++) begin : g_cell
        cnt_t c;
        lockset_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .inc      (acq_mask[i]),
            .dec      (rel_mask[i]),
            .cnt      (c),
            .zero_hit (zero_hits[i])
        );
        assign lockset[i] = (c != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) rel_err <= 1'b0;
        else     rel_err <= |zero_hits;
    end

    a_r6_err_after_release: assert property (@(posedge clk) disable iff (rst)
        rel_err |-> $past(rel_valid));
    a_r8_reset_empty: assert property (@(posedge clk)
        $past(rst) |-> (lockset == '0 && !rel_err));
endmodule

// File: tb/tb_lockset_bloom_reg.sv
module tb_lockset_bloom_reg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acq_valid = 1'b0;
    logic [15:0] acq_addr = '0;
    logic        rel_valid = 1'b0;
    logic [15:0] rel_addr = '0;
    logic [15:0] lockset;
    logic        rel_err;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    lockset_bloom_reg dut (
        .clk(clk), .rst(rst),
        .acq_valid(acq_valid), .acq_addr(acq_addr),
        .rel_valid(rel_valid), .rel_addr(rel_addr),
        .lockset(lockset), .rel_err(rel_err)
    );

    // Lock addresses and the bits each one selects:
    //   A=0000 -> 1111, B=00FF -> 8888, C=FF00 -> 8888 (B and C collide),
    //   D=0055 -> 2222, E=00AA -> 4444, F=00E4 -> 8421.
    // Vector layout: {acq_v, acq_addr, rel_v, rel_addr, exp_lockset, exp_err}.
    localparam logic [50:0] TBL [0:13] = '{
        {1'b1, 16'h0000, 1'b0, 16'h0000, 16'h1111, 1'b0}, // R2 acquire A
        {1'b1, 16'h00FF, 1'b0, 16'h0000, 16'h9999, 1'b0}, // R3 acquire B
        {1'b1, 16'hFF00, 1'b0, 16'h0000, 16'h9999, 1'b0}, // R2 C collides with B
        {1'b0, 16'h0000, 1'b1, 16'h00FF, 16'h9999, 1'b0}, // R4 shared bits remain
        {1'b0, 16'h0000, 1'b1, 16'hFF00, 16'h1111, 1'b0}, // R4 bits clear
        {1'b0, 16'h0000, 1'b1, 16'h0055, 16'h1111, 1'b1}, // R6 release of free lock
        {1'b1, 16'h0055, 1'b0, 16'h0000, 16'h3333, 1'b0}, // R3 acquire D
        {1'b1, 16'h00AA, 1'b1, 16'h0055, 16'h5555, 1'b0}, // R7 both ports
        {1'b1, 16'h0055, 1'b1, 16'h0055, 16'h7777, 1'b1}, // R7 release first at zero
        {1'b0, 16'h0000, 1'b1, 16'h00AA, 16'h3333, 1'b0}, // R4 release E
        {1'b1, 16'h00E4, 1'b0, 16'h0000, 16'hB733, 1'b0}, // R2 mixed indices
        {1'b0, 16'h0000, 1'b1, 16'h0000, 16'hA623, 1'b0}, // R1 partial clear
        {1'b0, 16'h0000, 1'b1, 16'h00E4, 16'h2222, 1'b0}, // R4 release F
        {1'b0, 16'h0000, 1'b1, 16'h0055, 16'h0000, 1'b0}  // R1 empty
    };

    task automatic check(input string req, input logic [15:0] exp_ls, input logic exp_err);
        checks++;
        if (lockset !== exp_ls || rel_err !== exp_err) begin
            errors++;
            $display("FAIL %s: lockset=%h rel_err=%b expected lockset=%h rel_err=%b",
                     req, lockset, rel_err, exp_ls, exp_err);
        end
    endtask

    task automatic step(input logic av, input logic [15:0] aa,
                        input logic rv, input logic [15:0] ra);
        @(negedge clk);
        acq_valid = av; acq_addr = aa; rel_valid = rv; rel_addr = ra;
        @(posedge clk);
        #2;
        @(negedge clk);
        acq_valid = 1'b0; rel_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        check("R8 reset state", 16'h0000, 1'b0);

        for (int i = 0; i < 14; i++) begin
            step(TBL[i][50], TBL[i][49:34], TBL[i][33], TBL[i][32:17]);
            #0;
            check($sformatf("R1 vector %0d", i), TBL[i][16:1], TBL[i][0]);
        end

        // R3/R5: four acquires of A; the fourth overflows the counters.
        for (int i = 0; i < 4; i++) step(1'b1, 16'h0000, 1'b0, 16'h0);
        check("R3 saturated", 16'h1111, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b0, 16'h0, 1'b1, 16'h0000);
        check("R5 floor after three releases", 16'h1111, 1'b0);
        step(1'b0, 16'h0, 1'b1, 16'h0000);
        check("R5 floor holds without error", 16'h1111, 1'b0);

        // R8: reset in the middle of operation.
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R8 reset clears", 16'h0000, 1'b0);
        step(1'b0, 16'h0, 1'b1, 16'h0000);
        check("R6 zero after reset", 16'h0000, 1'b1);
        step(1'b0, 16'h0, 1'b0, 16'h0000);
        check("R6 pulse one cycle", 16'h0000, 1'b0);
        step(1'b1, 16'h0000, 1'b0, 16'h0);
        step(1'b0, 16'h0, 1'b1, 16'h0000);
        check("R5 overflow mark cleared by reset", 16'h0000, 1'b0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule